// File: doc/BRIEF.md
# Quadrature Output with Edge-Rate Limiter

This block produces incremental A/B quadrature outputs that follow a target position count. The count arrives already scaled to the output resolution. On each clock the internal output count moves at most one quadrature state toward the target. A programmable minimum spacing between successive A/B edges caps the output frequency.

When the target moves faster than the spacing allows, the outputs fall behind the true position and a limiting flag is raised. Once the target slows down, the outputs keep stepping until they match it. A persistence counter measures how long the block has been limiting since it last matched the target. When that counter reaches a programmable threshold, a sticky fatal fault is raised and all stepping stops until reset. The limiting condition can also be routed to an interrupt request through an enable input.

Top module: `quad_edge_limiter`

## Requirements
- R1: While reset is asserted and on the first cycle after it, A, B, limiting, irq and fault are all 0, and the output count is 0.
- R2: The outputs encode the low two bits c of the output count as A = c[1] and B = c[1] XOR c[0]. Counting up therefore gives AB = 00, 01, 11, 10. The direction of each step is toward the target along the shorter path: up when the MSB of (target − count) modulo 2^POS_W is 0, and down otherwise.
- R3: In any clock at most one of A and B changes. A step occurs in exactly the clocks where the count differs from the target, the spacing has elapsed and no fault is set.
- R4: Two successive A/B edges are at least min_gap+1 clocks apart. With min_gap = 0, an edge may occur on every clock.
- R5: The limiting output is 1 in the cycle after a clock in which the count differed from the target, the spacing had not yet elapsed and no fault was set. Otherwise it is 0.
- R6: After the target stops changing, the outputs keep stepping until the output count equals the target, and then they hold.
- R7: The persistence counter clears whenever the count equals the target and increases on every limiting clock. The fault sets on the limiting clock in which the counter, after increasing, is at least persist_limit.
- R8: Once set, the fault stays set until reset, and A and B no longer change.
- R9: irq equals the limiting output when irq_en was 1 on the clock that produced it. With irq_en = 0, irq stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| target_pos | input | POS_W | Target position count at output resolution |
| min_gap | input | GAP_W | Extra clocks required between edges (0 gives one edge per clock) |
| persist_limit | input | PER_W | Persistence threshold for the fatal fault |
| irq_en | input | 1 | Routes the limiting condition to irq |
| a_out | output | 1 | Quadrature channel A |
| b_out | output | 1 | Quadrature channel B |
| limiting | output | 1 | Output is behind and held back by the spacing rule |
| irq | output | 1 | Interrupt request for limiting |
| fault | output | 1 | Sticky fatal fault; stepping halted |

## Verification
The limiting clock that pushes the persistence count to the threshold also sets the fault. That single edge must therefore raise limiting and fault together, and the fault must then block the very next step. The bench provokes this with a large target jump, a wide spacing and a small threshold. A cycle-accurate behavioural model checks the cycle in which both flags rise and confirms that A/B freeze from then on. Changes of direction, including wrap around zero, are also judged against the model on every clock.

// File: rtl/qel_pkg.sv
package qel_pkg;

    typedef enum logic {
        QEL_DOWN = 1'b0,
        QEL_UP   = 1'b1
    } qel_dir_e;

    // Quadrature pattern {A,B} for the two low bits of a count
    function automatic logic [1:0] qel_gray(input logic [1:0] c);
        return {c[1], c[1] ^ c[0]};
    endfunction

endpackage

// File: rtl/qel_gap_timer.sv
module qel_gap_timer #(
    parameter int GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [GAP_W-1:0] min_gap,
    output logic             allowed
);
    localparam logic [GAP_W-1:0] GAP_MAX = {GAP_W{1'b1}};

    typedef struct packed {
        logic [GAP_W-1:0] since;
    } gap_st_t;

    gap_st_t g_d, g_q;

    assign allowed = (g_q.since >= min_gap);

    always_comb begin
        g_d = g_q;
        if (step) begin
            g_d.since = '0;
        end else if (g_q.since != GAP_MAX) begin
            g_d.since = g_q.since + GAP_W'(1);
        end
    end

    // Start as if a full gap has already passed
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q.since <= GAP_MAX;
        end else begin
            g_q <= g_d;
        end
    end

endmodule

// File: rtl/qel_stepper.sv
module qel_stepper
    import qel_pkg::*;
#(
    parameter int POS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [POS_W-1:0] target_pos,
    input  logic             allowed,
    input  logic             halt,
    output logic             behind,
    output logic             step,
    output logic             a_out,
    output logic             b_out
);
    typedef struct packed {
        logic [POS_W-1:0] cnt;
        logic [1:0]       ab;
    } stp_st_t;

    stp_st_t s_d, s_q;
    logic [POS_W-1:0] diff;
    qel_dir_e         dir;

    assign diff   = target_pos - s_q.cnt;
    assign dir    = diff[POS_W-1] ? QEL_DOWN : QEL_UP;
    assign behind = (diff != '0);
    assign step   = behind & allowed & ~halt;

    always_comb begin
        s_d = s_q;
        if (step) begin
            if (dir == QEL_UP) begin
                s_d.cnt = s_q.cnt + POS_W'(1);
            end else begin
                s_d.cnt = s_q.cnt - POS_W'(1);
            end
        end
        s_d.ab = qel_gray(s_d.cnt[1:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign a_out = s_q.ab[1];
    assign b_out = s_q.ab[0];

endmodule

// File: rtl/qel_persist_mon.sv
module qel_persist_mon #(
    parameter int PER_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             behind,
    input  logic             allowed,
    input  logic             irq_en,
    input  logic [PER_W-1:0] persist_limit,
    output logic             limiting,
    output logic             irq,
    output logic             fault
);
    localparam logic [PER_W-1:0] PER_MAX = {PER_W{1'b1}};

    typedef struct packed {
        logic [PER_W-1:0] persist;
        logic             lim;
        logic             irq;
        logic             fault;
    } mon_st_t;

    mon_st_t m_d, m_q;
    logic           lim_now;
    logic [PER_W:0] persist_inc;

    assign lim_now     = behind & ~allowed & ~m_q.fault;
    assign persist_inc = {1'b0, m_q.persist} + (PER_W+1)'(1);

    always_comb begin
        m_d       = m_q;
        m_d.lim   = lim_now;
        m_d.irq   = lim_now & irq_en;
        if (!behind) begin
            m_d.persist = '0;
        end else if (lim_now && m_q.persist != PER_MAX) begin
            m_d.persist = persist_inc[PER_W-1:0];
        end
        if (lim_now && persist_inc >= {1'b0, persist_limit}) begin
            m_d.fault = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q <= '0;
        end else begin
            m_q <= m_d;
        end
    end

    assign limiting = m_q.lim;
    assign irq      = m_q.irq;
    assign fault    = m_q.fault;

endmodule

// File: rtl/quad_edge_limiter.sv
module quad_edge_limiter #(
    parameter int POS_W = 16,
    parameter int GAP_W = 8,
    parameter int PER_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [POS_W-1:0] target_pos,
    input  logic [GAP_W-1:0] min_gap,
    input  logic [PER_W-1:0] persist_limit,
    input  logic             irq_en,
    output logic             a_out,
    output logic             b_out,
    output logic             limiting,
    output logic             irq,
    output logic             fault
);
    logic allowed;
    logic behind;
    logic step;

    qel_gap_timer #(.GAP_W(GAP_W)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (step),
        .min_gap (min_gap),
        .allowed (allowed)
    );

    qel_stepper #(.POS_W(POS_W)) u_step (
        .clk        (clk),
        .rst_n      (rst_n),
        .target_pos (target_pos),
        .allowed    (allowed),
        .halt       (fault),
        .behind     (behind),
        .step       (step),
        .a_out      (a_out),
        .b_out      (b_out)
    );

    qel_persist_mon #(.PER_W(PER_W)) u_mon (
        .clk           (clk),
        .rst_n         (rst_n),
        .behind        (behind),
        .allowed       (allowed),
        .irq_en        (irq_en),
        .persist_limit (persist_limit),
        .limiting      (limiting),
        .irq           (irq),
        .fault         (fault)
    );

endmodule

// File: rtl/qel_checker.sv
module qel_checker #(
    parameter int GAP_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [GAP_W-1:0] min_gap,
    input logic             irq_en,
    input logic             a_out,
    input logic             b_out,
    input logic             limiting,
    input logic             irq,
    input logic             fault
);
    logic             a_prev, b_prev, seen_edge, cfg_moved;
    logic [GAP_W-1:0] gap_prev;
    logic [GAP_W:0]   since;
    logic             edge_now;

    assign edge_now = (a_out != a_prev) || (b_out != b_prev);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_prev    <= 1'b0;
            b_prev    <= 1'b0;
            seen_edge <= 1'b0;
            cfg_moved <= 1'b0;
            gap_prev  <= '0;
            since     <= '0;
        end else begin
            a_prev   <= a_out;
            b_prev   <= b_out;
            gap_prev <= min_gap;
            if (edge_now) begin
                seen_edge <= 1'b1;
                cfg_moved <= 1'b0;
                since     <= '0;
            end else begin
                if (min_gap != gap_prev) cfg_moved <= 1'b1;
                if (since != {(GAP_W+1){1'b1}}) since <= since + (GAP_W+1)'(1);
            end
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> (!a_out && !b_out && !limiting && !irq && !fault));

    // R3
    single_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(a_out) || $stable(b_out));

    // R4
    edge_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_now && seen_edge && !cfg_moved && min_gap == gap_prev)
            |-> (since >= {1'b0, min_gap}));

    // R8
    fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> fault);

    // R8
    fault_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> ($stable(a_out) && $stable(b_out)));

    // R9
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> limiting);

    // R9
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(irq_en)) |-> !irq);

endmodule

bind quad_edge_limiter qel_checker #(.GAP_W(GAP_W)) u_qel_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .min_gap  (min_gap),
    .irq_en   (irq_en),
    .a_out    (a_out),
    .b_out    (b_out),
    .limiting (limiting),
    .irq      (irq),
    .fault    (fault)
);

// File: tb/quad_edge_limiter_test.sv
module quad_edge_limiter_test;
    localparam int POS_W = 16;
    localparam int GAP_W = 8;
    localparam int PER_W = 12;
    localparam int PMASK = (1 << POS_W) - 1;
    localparam int GMAX  = (1 << GAP_W) - 1;
    localparam int PMAX  = (1 << PER_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [POS_W-1:0] target_pos = '0;
    logic [GAP_W-1:0] min_gap = '0;
    logic [PER_W-1:0] persist_limit = 12'd1000;
    logic             irq_en = 1'b1;
    logic             a_out, b_out, limiting, irq, fault;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int last_edge = -1000;
    logic pa = 1'b0, pb = 1'b0;

    // behavioural reference state
    int m_pos = 0, m_gap = GMAX, m_pers = 0;
    bit m_fault = 0, m_lim = 0, m_irq = 0;

    quad_edge_limiter #(.POS_W(POS_W), .GAP_W(GAP_W), .PER_W(PER_W)) uut (
        .clk(clk), .rst_n(rst_n), .target_pos(target_pos), .min_gap(min_gap),
        .persist_limit(persist_limit), .irq_en(irq_en), .a_out(a_out),
        .b_out(b_out), .limiting(limiting), .irq(irq), .fault(fault)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pos = 0; m_gap = GMAX; m_pers = 0;
            m_fault = 0; m_lim = 0; m_irq = 0;
        end else begin
            int diff;
            bit behind, allowed, stp, lim;
            diff    = (int'(target_pos) - m_pos) & PMASK;
            behind  = diff != 0;
            allowed = m_gap >= int'(min_gap);
            stp     = behind && allowed && !m_fault;
            lim     = behind && !allowed && !m_fault;
            if (lim && (m_pers + 1) >= int'(persist_limit)) m_fault = 1;
            if (!behind) m_pers = 0;
            else if (lim && m_pers < PMAX) m_pers = m_pers + 1;
            if (stp) m_pos = (diff < (1 << (POS_W - 1))) ? ((m_pos + 1) & PMASK)
                                                          : ((m_pos - 1) & PMASK);
            m_gap = stp ? 0 : ((m_gap < GMAX) ? m_gap + 1 : GMAX);
            m_lim = lim;
            m_irq = lim && irq_en;
        end
    end

    always @(negedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            check(0, "watchdog", cyc, 100000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
        if (rst_n) begin
            int ea, eb;
            ea = (m_pos >> 1) & 1;
            eb = ((m_pos >> 1) ^ m_pos) & 1;
            check(a_out == ea[0], "R2 A", a_out, ea);
            check(b_out == eb[0], "R2 B", b_out, eb);
            check(limiting == m_lim, "R5 limiting", limiting, m_lim);
            check(irq == m_irq, "R9 irq", irq, m_irq);
            check(fault == m_fault, "R7 fault", fault, m_fault);
            if (a_out != pa || b_out != pb) begin
                check(!(a_out != pa && b_out != pb), "R3 one bit", 2, 1);
                check(cyc - last_edge >= int'(min_gap) + 1, "R4 spacing",
                      cyc - last_edge, int'(min_gap) + 1);
                last_edge = cyc;
            end
        end
        pa = a_out;
        pb = b_out;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick(1);
        check(!a_out && !b_out && !limiting && !irq && !fault, "R1 reset",
              {a_out, b_out, limiting, irq, fault}, 0);
        tick(2);
        rst_n = 1'b1;
        tick(1);
        check(!a_out && !b_out && !limiting && !irq && !fault, "R1 after reset",
              {a_out, b_out, limiting, irq, fault}, 0);
        last_edge = -1000;
    endtask

    task automatic set_gap(input int g);
        min_gap = g[GAP_W-1:0];
        last_edge = -1000;
    endtask

    initial begin
        tick(1);
        do_reset();

        // R2: slow upward ramp, explicit Gray pattern
        for (int i = 1; i <= 8; i++) begin
            target_pos = target_pos + 1'b1;
            tick(3);
            check({a_out, b_out} == {i[1], i[1] ^ i[0]}, "R2 gray up",
                  {a_out, b_out}, {i[1], i[1] ^ i[0]});
        end
        // R4: min_gap 0, jump steps on every clock without limiting
        target_pos = target_pos + 16'd5;
        tick(8);
        check(!limiting && !fault, "R4 full rate", limiting, 0);

        // R5 R6: wide spacing, large jump, then catch up
        set_gap(3);
        target_pos = target_pos + 16'd10;
        tick(2);
        check(limiting == 1'b1, "R5 limiting raised", limiting, 1);
        tick(60);
        check(m_pos == int'(target_pos) && !limiting, "R6 caught up", m_pos, target_pos);

        // R2: downward across zero
        set_gap(1);
        target_pos = 16'd3;
        tick(60);
        target_pos = 16'hFFFB;
        tick(30);
        check(m_pos == 16'hFFFB, "R6 wrap down", m_pos, 16'hFFFB);

        // R9: irq masked while limiting
        irq_en = 1'b0;
        set_gap(5);
        target_pos = target_pos + 16'd6;
        tick(3);
        check(limiting && !irq, "R9 masked", irq, 0);
        tick(60);
        irq_en = 1'b1;

        // R7 R8: persistent limiting escalates to fault
        persist_limit = 12'd5;
        set_gap(4);
        target_pos = target_pos + 16'd20;
        tick(20);
        check(fault == 1'b1, "R7 fault raised", fault, 1);
        begin
            logic sa, sb;
            sa = a_out; sb = b_out;
            target_pos = target_pos - 16'd40;
            tick(30);
            check(a_out == sa && b_out == sb && fault, "R8 frozen sticky",
                  {fault, a_out, b_out}, {1'b1, sa, sb});
        end

        // R1 R7: reset clears fault; persistence clears on equality
        persist_limit = 12'd1000;
        target_pos = '0;
        set_gap(0);
        do_reset();
        persist_limit = 12'd3;
        set_gap(2);
        for (int k = 0; k < 6; k++) begin
            target_pos = target_pos + 1'b1;
            tick(6);
        end
        check(!fault, "R7 cleared on match", fault, 0);

        tick(4);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule